// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block judges whether a PLL-derived clock runs at the frequency of a reference clock. It divides the reference clock by one, two or four and counts the divided ticks to set a measurement window of 2^WIN_LOG2 ticks. The PLL clock is counted in its own domain. At the end of each window, a toggle handshake through two-flop synchronizers in each direction carries the PLL count back to the reference domain. There the absolute difference from the window length is compared against a tolerance taken from a 3-bit lock code. The lock flag is raised when the difference is inside that tolerance. Once raised, the flag stays up until the difference exceeds a wider limit. That wider limit is set by a 3-bit hysteresis code.

Two pairs of codes are held. One pair applies while calibration runs. The other pair applies for normal running from the first rising edge of the calibration-done input onward. A tracking-select output follows the lock flag. It tells a downstream clock-recovery loop to follow incoming data when locked, and to follow the reference when unlocked.

Top module: `freq_lock_det`

## Requirements
- R1: With lock code L, the lock tolerance is T = 2^WIN_LOG2 >> (TOL_BASE - L). An unlocked detector becomes locked after a window whose count difference is at most T.
- R2: With hysteresis code H, a locked detector becomes unlocked only after a window whose difference is greater than T << H. A difference in the band between T and T << H leaves the flag unchanged.
- R3: With H = 0, the lock and unlock limits are equal, so any difference greater than T unlocks.
- R4: Until cal_done has risen once after reset, the calibration codes are used. After the first rise, the run codes are used, and this holds even if cal_done falls again.
- R5: track_data_o is 1 (follow data) whenever lock_o is 1, and 0 (follow reference) whenever lock_o is 0.
- R6: ref_div_sel = 0 divides the reference by 1, = 1 divides it by 2, and = 2 or 3 divides it by 4. The window is counted in divided ticks, so the PLL clock is expected to run at the divided reference frequency.
- R7: A synchronous reset on rst clears lock_o and track_data_o in the next cycle.
- R8: lock_o changes only at the evaluation that follows each window's handshake. The first measurement after reset is discarded.
- R9: The difference is absolute, so a PLL clock that is slow by some amount is judged the same as one that is fast by the same amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; clocks the window and the decision logic |
| rst | input | 1 | Synchronous reset, active high, in the ref_clk domain |
| pll_clk | input | 1 | PLL-derived clock under measurement |
| ref_div_sel | input | 2 | Reference pre-divide select: 0 = /1, 1 = /2, 2 or 3 = /4 |
| cal_done | input | 1 | Calibration complete; its first rise switches to the run codes |
| cal_lock_code | input | 3 | Lock tolerance code used during calibration |
| cal_hys_code | input | 3 | Hysteresis code used during calibration |
| run_lock_code | input | 3 | Lock tolerance code used in normal running |
| run_hys_code | input | 3 | Hysteresis code used in normal running |
| lock_o | output | 1 | Frequency lock flag |
| track_data_o | output | 1 | 1 = recovery loop follows data, 0 = follows the reference |

## Verification
The PLL period is set to give a chosen count offset from the window length. Each lock/hysteresis code pair is taken through a fixed sequence of offsets. The sequence has offsets inside the lock limit, inside the hysteresis band reached from both the locked and the unlocked state, and beyond the unlock limit. This separates the acquire rule from the release rule and shows whether the band holds state. The sweep runs once in the calibration phase and once in the run phase, with the unused pair set so that it would give a different answer; this shows which pair is in force. Alternate configurations use PLL clocks that are slow and fast by the same offset, which tests whether the difference is treated as absolute. Short runs with pre-divide by two and four check that the window scales with the divided reference.

// File: rtl/freq_lock_det.sv
`timescale 1ns/1ps
module freq_lock_det #(
  parameter int WIN_LOG2 = 14,
  parameter int TOL_BASE = 12,
  parameter int CODE_W   = 3
) (
  input  logic              ref_clk,
  input  logic              rst,
  input  logic              pll_clk,
  input  logic [1:0]        ref_div_sel,
  input  logic              cal_done,
  input  logic [CODE_W-1:0] cal_lock_code,
  input  logic [CODE_W-1:0] cal_hys_code,
  input  logic [CODE_W-1:0] run_lock_code,
  input  logic [CODE_W-1:0] run_hys_code,
  output logic              lock_o,
  output logic              track_data_o
);
  localparam int CW = WIN_LOG2 + 3;
  localparam logic [CW-1:0] WIN_LEN = {{(CW-1){1'b0}}, 1'b1} << WIN_LOG2;

  // reference domain: pre-divider and window
  logic [1:0]          div_cnt;
  logic [1:0]          div_max;
  logic                tick;
  logic [WIN_LOG2-1:0] win_cnt;
  logic                win_end;
  logic                req_tgl;
  logic [2:0]          ack_sync;
  logic                ack_edge;
  logic                primed;
  logic                cal_q;
  logic                run_phase;
  logic                lock_q;

  assign div_max  = (ref_div_sel == 2'd0) ? 2'd0 : (ref_div_sel == 2'd1) ? 2'd1 : 2'd3;
  assign tick     = (div_cnt >= div_max);
  assign win_end  = tick && (&win_cnt);
  assign ack_edge = ack_sync[1] ^ ack_sync[2];

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      div_cnt  <= '0;
      win_cnt  <= '0;
      req_tgl  <= 1'b0;
      ack_sync <= '0;
    end else begin
      div_cnt  <= tick ? 2'd0 : div_cnt + 2'd1;
      if (tick) win_cnt <= win_cnt + 1'b1;
      if (win_end) req_tgl <= ~req_tgl;
      ack_sync <= {ack_sync[1:0], ack_tgl};
    end
  end

  // PLL domain: local reset, count, capture on request
  logic [1:0]    prst_sync;
  logic          prst;
  logic [2:0]    req_sync;
  logic          req_edge;
  logic [CW-1:0] pll_cnt;
  logic [CW-1:0] pll_hold;
  logic          ack_tgl;

  assign prst     = prst_sync[1];
  assign req_edge = req_sync[1] ^ req_sync[2];

  always_ff @(posedge pll_clk) prst_sync <= {prst_sync[0], rst};

  always_ff @(posedge pll_clk) begin
    if (prst) begin
      req_sync <= '0;
      pll_cnt  <= '0;
      pll_hold <= '0;
      ack_tgl  <= 1'b0;
    end else begin
      req_sync <= {req_sync[1:0], req_tgl};
      if (req_edge) begin
        pll_hold <= pll_cnt;
        pll_cnt  <= {{(CW-1){1'b0}}, 1'b1};
        ack_tgl  <= ~ack_tgl;
      end else if (pll_cnt != '1) begin
        pll_cnt <= pll_cnt + 1'b1;
      end
    end
  end

  // decision in the reference domain
  logic [CODE_W-1:0] lcode;
  logic [CODE_W-1:0] hcode;
  logic [4:0]        shamt;
  logic [CW-1:0]     lock_thr;
  logic [CW-1:0]     unlock_thr;
  logic [CW-1:0]     diff;
  logic              eval;

  assign lcode      = run_phase ? run_lock_code : cal_lock_code;
  assign hcode      = run_phase ? run_hys_code  : cal_hys_code;
  assign shamt      = 5'(TOL_BASE) - 5'(lcode);
  assign lock_thr   = WIN_LEN >> shamt;
  assign unlock_thr = lock_thr << hcode;
  assign diff       = (pll_hold >= WIN_LEN) ? pll_hold - WIN_LEN : WIN_LEN - pll_hold;
  assign eval       = ack_edge && primed;

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      primed    <= 1'b0;
      cal_q     <= 1'b0;
      run_phase <= 1'b0;
      lock_q    <= 1'b0;
    end else begin
      cal_q <= cal_done;
      if (cal_done && !cal_q) run_phase <= 1'b1;
      if (ack_edge) primed <= 1'b1;
      if (eval) begin
        if (!lock_q && diff <= lock_thr)  lock_q <= 1'b1;
        if (lock_q && diff > unlock_thr)  lock_q <= 1'b0;
      end
    end
  end

  assign lock_o       = lock_q;
  assign track_data_o = lock_q;

  AST_ACQUIRE_IN_TOL: assert property (@(posedge ref_clk) disable iff (rst)
    $rose(lock_q) |-> $past(diff <= lock_thr)); // R1
  AST_RELEASE_BEYOND_HYS: assert property (@(posedge ref_clk) disable iff (rst)
    $fell(lock_q) |-> $past(diff > unlock_thr)); // R2
  AST_PHASE_STICKY: assert property (@(posedge ref_clk) disable iff (rst)
    run_phase |=> run_phase); // R4
  AST_RESET_UNLOCKS: assert property (@(posedge ref_clk)
    rst |=> !lock_o); // R7
  AST_LOCK_ONLY_AT_EVAL: assert property (@(posedge ref_clk) disable iff (rst)
    !eval |=> $stable(lock_q)); // R8
  AST_HOLD_STABLE_AT_EVAL: assert property (@(posedge ref_clk) disable iff (rst)
    eval |-> $stable(pll_hold)); // R8
endmodule

// File: tb/freq_lock_det_tb_top.sv
`timescale 1ns/1ps
module freq_lock_det_tb_top;
  localparam real CLK_PERIOD = 10.0;
  localparam int  WL = 8;
  localparam int  WIN = 1 << WL;

  logic       ref_clk = 0;
  logic       pll_clk = 0;
  logic       rst = 1;
  logic [1:0] ref_div_sel = 0;
  logic       cal_done = 0;
  logic [2:0] cal_lock_code = 7, cal_hys_code = 2, run_lock_code = 5, run_hys_code = 0;
  logic       lock_o, track_data_o;
  realtime    pll_half = CLK_PERIOD / 2.0;

  int checks = 0;
  int failures = 0;
  bit exp_lock = 0;
  bit known = 1;
  int cur_div = 1;

  freq_lock_det #(.WIN_LOG2(WL)) dut_i (
    .ref_clk(ref_clk), .rst(rst), .pll_clk(pll_clk), .ref_div_sel(ref_div_sel),
    .cal_done(cal_done), .cal_lock_code(cal_lock_code), .cal_hys_code(cal_hys_code),
    .run_lock_code(run_lock_code), .run_hys_code(run_hys_code),
    .lock_o(lock_o), .track_data_o(track_data_o));

  always #(CLK_PERIOD / 2.0) ref_clk = ~ref_clk;
  initial forever #(pll_half) pll_clk = ~pll_clk;

  task automatic check(input bit got, input bit exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic wait_windows(input int n);
    repeat (n * WIN * cur_div + 40) @(negedge ref_clk);
  endtask

  task automatic set_offset(input int d);
    pll_half = (real'(WIN) * cur_div * CLK_PERIOD) / (real'(WIN) + d) / 2.0;
  endtask

  // one offset step against codes lc/hc, expected state from the requirements
  task automatic step(input int d, input int lc, input int hc, input string phase);
    int lt, ut, ad;
    string tag;
    lt = WIN >> (12 - lc);
    ut = lt << hc;
    ad = (d < 0) ? -d : d;
    set_offset(d);
    wait_windows(3);
    if ((ad >= lt - 2 && ad <= lt + 2) || (ad >= ut - 2 && ad <= ut + 2)) begin
      known = 0;
    end else if (ad < lt) begin
      exp_lock = 1; known = 1;
    end else if (ad > ut) begin
      exp_lock = 0; known = 1;
    end
    if (ad < lt) tag = "R1";
    else if (hc == 0) tag = "R3";
    else tag = "R2";
    if (known) begin
      check(lock_o, exp_lock, {tag, "/", phase, (d < 0) ? "/R9" : "", (cur_div != 1) ? "/R6" : ""});
      check(track_data_o, exp_lock, "R5");
    end
  endtask

  initial begin
    int offs[7] = '{0, 12, 40, 12, 2, 20, 80};
    repeat (20) @(negedge ref_clk);
    check(lock_o, 0, "R7 reset lock");
    check(track_data_o, 0, "R7 reset track");
    rst = 0;
    // first window discarded even with exact frequency
    repeat (WIN + WIN / 2) @(negedge ref_clk);
    check(lock_o, 0, "R8 first window discarded");
    wait_windows(2);
    check(lock_o, 1, "R8 lock after second window");
    exp_lock = 1; known = 1;

    // calibration phase sweep; run codes set strict (lt=2) to expose misuse
    run_lock_code = 5; run_hys_code = 0;
    for (int lc = 6; lc <= 7; lc++)
      for (int hc = 0; hc <= 3; hc++) begin
        cal_lock_code = 3'(lc); cal_hys_code = 3'(hc);
        for (int k = 0; k < 7; k++)
          step(((hc % 2) == 1) ? -offs[k] : offs[k], lc, hc, "R4 cal");
      end

    // switch to run codes; drop cal_done again, selection must stay
    set_offset(0); wait_windows(3); exp_lock = 1; known = 1;
    cal_lock_code = 7; cal_hys_code = 3;
    @(negedge ref_clk) cal_done = 1;
    repeat (4) @(negedge ref_clk);
    cal_done = 0;
    for (int lc = 6; lc <= 7; lc++)
      for (int hc = 0; hc <= 3; hc++) begin
        run_lock_code = 3'(lc); run_hys_code = 3'(hc);
        for (int k = 0; k < 7; k++)
          step(((lc + hc) % 2 == 1) ? -offs[k] : offs[k], lc, hc, "R4 run");
      end

    // reference pre-divide
    run_lock_code = 7; run_hys_code = 2;
    for (int s = 1; s <= 3; s++) begin
      ref_div_sel = 2'(s);
      cur_div = (s == 1) ? 2 : 4;
      step(0, 7, 2, "div");
      step(40, 7, 2, "div");
      step(0, 7, 2, "div");
    end

    // reset while locked
    check(lock_o, 1, "R7 locked before reset");
    @(negedge ref_clk) rst = 1;
    @(negedge ref_clk);
    check(lock_o, 0, "R7 reset clears lock");
    check(track_data_o, 0, "R7 reset selects reference");
    rst = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge ref_clk);
    failures++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule